// File: doc/BRIEF.md
# Logical Shift-Right Execution Unit

This unit performs the logical shift-right instruction of an 8/16-bit accumulator CPU core. The operand is either the accumulator or a byte or halfword in memory. A memory operand is fetched, shifted and stored back over a byte-wide request/ready port. The caller supplies the opcode and the width-mode bit, along with the low byte of the direct-page register, a page-crossing hint and a compatibility-mode bit. For memory forms it also supplies the already computed effective address.

After each operation the unit returns four things: the accumulator, the status byte with carry, zero and negative updated, the instruction length in bytes and the architectural cycle count. The cycle count varies with operand width, direct-page alignment and page crossing. An unrecognised opcode is reported and nothing else changes. A start pulse begins an operation. A one-cycle done pulse marks the results valid, and they stay on the outputs until the next operation completes.

Top module: `lsr_exec_unit`

## Requirements
- R1: Carry (status bit 0) takes the operand's bit 0 as it was before the shift. The operand moves one place right and a zero enters at bit 7 in byte mode (`acc_byte_mode`=1) or at bit 15 otherwise.
- R2: Zero (status bit 1) is set when the result is zero at the active width. Negative (status bit 7) copies the result's top bit at the active width. All other status bits pass through unchanged.
- R3: For the accumulator form in byte mode, only the accumulator's low byte changes and the high byte is returned as it came in. Memory forms return the accumulator unchanged.
- R4: The base length and cycle count per opcode are: 0x4A (accumulator) 1 byte, 2 cycles; 0x4E (absolute) 3 bytes, 6 cycles; 0x46 (direct page) 2 bytes, 5 cycles; 0x5E (absolute indexed) 3 bytes, 7 cycles; 0x56 (direct page indexed) 2 bytes, 6 cycles.
- R5: In 16-bit mode a memory form adds 2 cycles and moves two bytes. It reads the low byte at the address and the high byte at the address plus one, then writes them back in the same order. In byte mode it reads once and writes once at the address.
- R6: Opcodes 0x46 and 0x56 add 1 cycle when `dp_reg_lo` is nonzero.
- R7: With `compat_mode` high, opcode 0x5E takes 1 cycle fewer when `page_cross` is low.
- R8: Any other opcode gives `bad_opcode`=1 with the done pulse. The accumulator and status come back unchanged, the length and cycle count are 0, and no memory access occurs.
- R9: A memory request holds its address, write enable and write data until `mem_ready` is seen. `done` is a one-cycle pulse: it comes the cycle after start for the accumulator form and for a bad opcode, and the cycle after the final write is accepted for a memory form.
- R10: A start pulse while `busy` is high is ignored. It does not alter the running operation and does not queue another.
- R11: After reset, `busy`, `done`, `mem_req` and `bad_opcode` are 0, and the accumulator, status, length and cycle-count outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to execute |
| opcode | input | 8 | Instruction opcode |
| acc_byte_mode | input | 1 | 1 = 8-bit accumulator, 0 = 16-bit |
| dp_reg_lo | input | 8 | Low byte of the direct-page register |
| page_cross | input | 1 | Indexed address crossed a page |
| compat_mode | input | 1 | Compatibility timing mode |
| eff_addr | input | ADDR_W | Effective address of a memory operand |
| acc_in | input | 16 | Accumulator before the instruction |
| flags_in | input | 8 | Status byte before the instruction |
| mem_req | output | 1 | Memory byte access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Access accepted this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| bad_opcode | output | 1 | Last operation had an unknown opcode |
| acc_out | output | 16 | Accumulator after the instruction |
| flags_out | output | 8 | Status byte after the instruction |
| instr_len | output | 2 | Instruction length in bytes |
| cycle_count | output | 4 | Architectural cycle count |

## Verification
A wrong sequencer state shows on the memory port within one access. It can appear as an extra or missing byte transfer, an address that is not the low/high pair, or a write that comes before its read. At the done pulse it shows as a wrong byte left in memory. A wrong latched width or opcode shows in the same done pulse as a cycle count off by one or two, a carry taken from the wrong bit, or a zero flag judged at the wrong width. A stray start that the unit accepts while busy shows as a second done pulse or as a changed accumulator.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    localparam int LSR_LEN_W = 2;
    localparam int LSR_CYC_W = 4;

    // status byte bit positions
    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 7;

    localparam logic [7:0] OPC_ACC   = 8'h4A;
    localparam logic [7:0] OPC_ABS   = 8'h4E;
    localparam logic [7:0] OPC_DP    = 8'h46;
    localparam logic [7:0] OPC_ABS_X = 8'h5E;
    localparam logic [7:0] OPC_DP_X  = 8'h56;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_RD_HI,
        ST_CALC,
        ST_WR_LO,
        ST_WR_HI
    } lsr_state_e;

    typedef struct packed {
        logic                 valid;
        logic                 is_mem;
        logic [LSR_LEN_W-1:0] len;
        logic [LSR_CYC_W-1:0] cyc;
    } lsr_timing_t;

endpackage

// File: rtl/lsr_timing.sv
module lsr_timing
    import lsr_pkg::*;
(
    input  logic [7:0]  opcode,
    input  logic        byte_mode,
    input  logic        dp_low_nz,
    input  logic        page_cross,
    input  logic        compat,
    output lsr_timing_t info
);
    localparam logic [LSR_CYC_W-1:0] WIDE_EXTRA = LSR_CYC_W'(2);
    localparam logic [LSR_CYC_W-1:0] ONE        = LSR_CYC_W'(1);

    logic [LSR_CYC_W-1:0] base_cyc;
    logic [LSR_LEN_W-1:0] base_len;
    logic                 known;
    logic                 mem_form;
    logic                 dp_form;
    logic                 idx_abs;

    always_comb begin
        known    = 1'b1;
        mem_form = 1'b1;
        dp_form  = 1'b0;
        idx_abs  = 1'b0;
        base_len = '0;
        base_cyc = '0;
        unique case (opcode)
            OPC_ACC: begin
                mem_form = 1'b0;
                base_len = LSR_LEN_W'(1);
                base_cyc = LSR_CYC_W'(2);
            end
            OPC_ABS: begin
                base_len = LSR_LEN_W'(3);
                base_cyc = LSR_CYC_W'(6);
            end
            OPC_DP: begin
                dp_form  = 1'b1;
                base_len = LSR_LEN_W'(2);
                base_cyc = LSR_CYC_W'(5);
            end
            OPC_ABS_X: begin
                idx_abs  = 1'b1;
                base_len = LSR_LEN_W'(3);
                base_cyc = LSR_CYC_W'(7);
            end
            OPC_DP_X: begin
                dp_form  = 1'b1;
                base_len = LSR_LEN_W'(2);
                base_cyc = LSR_CYC_W'(6);
            end
            default: begin
                known    = 1'b0;
                mem_form = 1'b0;
            end
        endcase
    end

    always_comb begin
        info.valid  = known;
        info.is_mem = mem_form;
        info.len    = base_len;
        info.cyc    = base_cyc
                    + ((mem_form && !byte_mode) ? WIDE_EXTRA : '0)
                    + ((dp_form && dp_low_nz) ? ONE : '0)
                    - ((idx_abs && compat && !page_cross) ? ONE : '0);
    end

endmodule

// File: rtl/lsr_shifter.sv
module lsr_shifter
    import lsr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0] val,
    input  logic              byte_mode,
    input  logic [7:0]        flags_in,
    output logic [DATA_W-1:0] res,
    output logic [7:0]        flags_out
);
    logic [DATA_W-1:0] wide_res;
    logic [BYTE_W-1:0] narrow_res;

    always_comb begin
        wide_res   = val >> 1;
        narrow_res = val[BYTE_W-1:0] >> 1;
        if (byte_mode) begin
            res = {val[DATA_W-1:BYTE_W], narrow_res};
        end else begin
            res = wide_res;
        end
        flags_out        = flags_in;
        flags_out[FLG_C] = val[0];
        if (byte_mode) begin
            flags_out[FLG_Z] = (narrow_res == '0);
            flags_out[FLG_N] = narrow_res[BYTE_W-1];
        end else begin
            flags_out[FLG_Z] = (wide_res == '0);
            flags_out[FLG_N] = wide_res[DATA_W-1];
        end
    end

endmodule

// File: rtl/lsr_exec_unit.sv
module lsr_exec_unit
    import lsr_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [7:0]           opcode,
    input  logic                 acc_byte_mode,
    input  logic [7:0]           dp_reg_lo,
    input  logic                 page_cross,
    input  logic                 compat_mode,
    input  logic [ADDR_W-1:0]    eff_addr,
    input  logic [15:0]          acc_in,
    input  logic [7:0]           flags_in,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [7:0]           mem_wdata,
    input  logic [7:0]           mem_rdata,
    input  logic                 mem_ready,
    output logic                 busy,
    output logic                 done,
    output logic                 bad_opcode,
    output logic [15:0]          acc_out,
    output logic [7:0]           flags_out,
    output logic [LSR_LEN_W-1:0] instr_len,
    output logic [LSR_CYC_W-1:0] cycle_count
);
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(1);

    typedef struct packed {
        lsr_state_e           st;
        logic                 bm;
        logic [ADDR_W-1:0]    addr;
        logic [DATA_W-1:0]    opnd;
        logic [DATA_W-1:0]    res;
        logic [DATA_W-1:0]    acc;
        logic [7:0]           flg;
        logic [LSR_LEN_W-1:0] len;
        logic [LSR_CYC_W-1:0] cyc;
        logic                 bad;
        logic                 done;
    } unit_state_t;

    unit_state_t cur_q, nxt_d;

    lsr_timing_t       tinfo;
    logic [DATA_W-1:0] sh_in;
    logic              sh_bm;
    logic [7:0]        sh_flg_in;
    logic [DATA_W-1:0] sh_res;
    logic [7:0]        sh_flg;
    logic              in_idle;

    assign in_idle = (cur_q.st == ST_IDLE);

    lsr_timing u_timing (
        .opcode     (opcode),
        .byte_mode  (acc_byte_mode),
        .dp_low_nz  (dp_reg_lo != 8'h00),
        .page_cross (page_cross),
        .compat     (compat_mode),
        .info       (tinfo)
    );

    always_comb begin
        sh_in     = in_idle ? acc_in        : cur_q.opnd;
        sh_bm     = in_idle ? acc_byte_mode : cur_q.bm;
        sh_flg_in = in_idle ? flags_in      : cur_q.flg;
    end

    lsr_shifter #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) u_shift (
        .val       (sh_in),
        .byte_mode (sh_bm),
        .flags_in  (sh_flg_in),
        .res       (sh_res),
        .flags_out (sh_flg)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (start) begin
                    nxt_d.bm   = acc_byte_mode;
                    nxt_d.addr = eff_addr;
                    nxt_d.acc  = acc_in;
                    nxt_d.flg  = flags_in;
                    nxt_d.bad  = !tinfo.valid;
                    nxt_d.len  = tinfo.valid ? tinfo.len : '0;
                    nxt_d.cyc  = tinfo.valid ? tinfo.cyc : '0;
                    if (!tinfo.valid) begin
                        nxt_d.done = 1'b1;
                    end else if (!tinfo.is_mem) begin
                        nxt_d.acc  = sh_res;
                        nxt_d.flg  = sh_flg;
                        nxt_d.done = 1'b1;
                    end else begin
                        nxt_d.opnd = '0;
                        nxt_d.st   = ST_RD_LO;
                    end
                end
            end
            ST_RD_LO: begin
                if (mem_ready) begin
                    nxt_d.opnd[BYTE_W-1:0] = mem_rdata;
                    nxt_d.st = cur_q.bm ? ST_CALC : ST_RD_HI;
                end
            end
            ST_RD_HI: begin
                if (mem_ready) begin
                    nxt_d.opnd[DATA_W-1:BYTE_W] = mem_rdata;
                    nxt_d.st = ST_CALC;
                end
            end
            ST_CALC: begin
                nxt_d.res = sh_res;
                nxt_d.flg = sh_flg;
                nxt_d.st  = ST_WR_LO;
            end
            ST_WR_LO: begin
                if (mem_ready) begin
                    if (cur_q.bm) begin
                        nxt_d.st   = ST_IDLE;
                        nxt_d.done = 1'b1;
                    end else begin
                        nxt_d.st = ST_WR_HI;
                    end
                end
            end
            ST_WR_HI: begin
                if (mem_ready) begin
                    nxt_d.st   = ST_IDLE;
                    nxt_d.done = 1'b1;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= '0;
            cur_q.st <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        mem_req   = (cur_q.st == ST_RD_LO) || (cur_q.st == ST_RD_HI)
                 || (cur_q.st == ST_WR_LO) || (cur_q.st == ST_WR_HI);
        mem_we    = (cur_q.st == ST_WR_LO) || (cur_q.st == ST_WR_HI);
        mem_addr  = ((cur_q.st == ST_RD_HI) || (cur_q.st == ST_WR_HI))
                  ? cur_q.addr + ADDR_STEP : cur_q.addr;
        mem_wdata = (cur_q.st == ST_WR_HI) ? cur_q.res[DATA_W-1:BYTE_W]
                                           : cur_q.res[BYTE_W-1:0];
    end

    assign busy        = !in_idle;
    assign done        = cur_q.done;
    assign bad_opcode  = cur_q.bad;
    assign acc_out     = cur_q.acc;
    assign flags_out   = cur_q.flg;
    assign instr_len   = cur_q.len;
    assign cycle_count = cur_q.cyc;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr)
                                  && $stable(mem_we) && $stable(mem_wdata)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_BAD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        done && bad_opcode |-> acc_out == $past(acc_in)
                               && flags_out == $past(flags_in)); // R8
    AST_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done && !bad_opcode |-> !flags_out[FLG_N]); // R2
    AST_CYC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done && !bad_opcode |-> cycle_count >= 4'd2 && cycle_count <= 4'd9
                                && instr_len != '0); // R4

endmodule

// File: tb/lsr_exec_unit_tb.sv
module lsr_exec_unit_tb;
    import lsr_pkg::*;

    localparam int ADDR_W = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] opcode = '0;
    logic acc_byte_mode = 1'b0;
    logic [7:0] dp_reg_lo = '0;
    logic page_cross = 1'b0;
    logic compat_mode = 1'b0;
    logic [ADDR_W-1:0] eff_addr = '0;
    logic [15:0] acc_in = '0;
    logic [7:0] flags_in = '0;
    logic mem_req, mem_we, mem_ready;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic busy, done, bad_opcode;
    logic [15:0] acc_out;
    logic [7:0] flags_out;
    logic [1:0] instr_len;
    logic [3:0] cycle_count;

    always #5 clk = ~clk;

    lsr_exec_unit #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .acc_byte_mode(acc_byte_mode), .dp_reg_lo(dp_reg_lo),
        .page_cross(page_cross), .compat_mode(compat_mode),
        .eff_addr(eff_addr), .acc_in(acc_in), .flags_in(flags_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .busy(busy), .done(done), .bad_opcode(bad_opcode),
        .acc_out(acc_out), .flags_out(flags_out),
        .instr_len(instr_len), .cycle_count(cycle_count)
    );

    // memory model with programmable wait states and an access log
    logic [7:0] mem [0:255];
    int lat = 0;
    int wcnt = 0;
    int log_n = 0;
    logic [7:0] log_addr [0:63];
    logic       log_we   [0:63];

    assign mem_rdata = mem[mem_addr[7:0]];
    assign mem_ready = mem_req && (wcnt >= lat);

    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            log_addr[log_n[5:0]] <= mem_addr[7:0];
            log_we[log_n[5:0]]   <= mem_we;
            log_n <= log_n + 1;
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            wcnt <= 0;
        end else if (mem_req) begin
            wcnt <= wcnt + 1;
        end
    end

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [7:0]  op;
        logic        bm;
        logic [7:0]  dp;
        logic        pc;
        logic        cm;
        logic [15:0] acc;
        logic [7:0]  flg;
        logic [7:0]  addr;
        logic [7:0]  mlo;
        logic [7:0]  mhi;
        logic [15:0] x_acc;
        logic [7:0]  x_flg;
        logic [1:0]  x_len;
        logic [3:0]  x_cyc;
        logic [7:0]  x_mlo;
        logic [7:0]  x_mhi;
        logic        x_bad;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        // op    bm    dp     pc    cm    acc       flg    addr   mlo    mhi    x_acc     x_flg  len   cyc    x_mlo  x_mhi  bad
        '{8'h4A,1'b1,8'h00,1'b0,1'b0,16'hAB81,8'h00,8'h10,8'h00,8'h00,16'hAB40,8'h01,2'd1,4'd2,8'h00,8'h00,1'b0}, // R1 R3
        '{8'h4A,1'b0,8'h00,1'b0,1'b0,16'h8001,8'hFF,8'h12,8'h00,8'h00,16'h4000,8'h7D,2'd1,4'd2,8'h00,8'h00,1'b0}, // R1 R2
        '{8'h4A,1'b1,8'h00,1'b0,1'b0,16'h1201,8'h80,8'h14,8'h00,8'h00,16'h1200,8'h03,2'd1,4'd2,8'h00,8'h00,1'b0}, // R2 byte zero
        '{8'h4A,1'b0,8'h00,1'b0,1'b0,16'h0001,8'h42,8'h16,8'h00,8'h00,16'h0000,8'h43,2'd1,4'd2,8'h00,8'h00,1'b0}, // R2
        '{8'h4E,1'b1,8'h00,1'b0,1'b0,16'h1234,8'h81,8'h20,8'h02,8'h55,16'h1234,8'h00,2'd3,4'd6,8'h01,8'h55,1'b0}, // R4
        '{8'h4E,1'b0,8'h00,1'b0,1'b0,16'h0000,8'h00,8'h30,8'h01,8'h80,16'h0000,8'h01,2'd3,4'd8,8'h00,8'h40,1'b0}, // R5
        '{8'h46,1'b1,8'h00,1'b0,1'b0,16'h0000,8'h00,8'h40,8'h01,8'h77,16'h0000,8'h03,2'd2,4'd5,8'h00,8'h77,1'b0}, // R4
        '{8'h46,1'b0,8'h05,1'b0,1'b0,16'h0000,8'h01,8'h50,8'h00,8'h00,16'h0000,8'h02,2'd2,4'd8,8'h00,8'h00,1'b0}, // R6
        '{8'h5E,1'b1,8'h00,1'b0,1'b0,16'h0000,8'h00,8'h60,8'hFE,8'h00,16'h0000,8'h00,2'd3,4'd7,8'h7F,8'h00,1'b0}, // R4
        '{8'h5E,1'b1,8'h00,1'b0,1'b1,16'h0000,8'h00,8'h70,8'h03,8'h00,16'h0000,8'h01,2'd3,4'd6,8'h01,8'h00,1'b0}, // R7
        '{8'h5E,1'b0,8'h00,1'b1,1'b1,16'h0000,8'h00,8'h80,8'h34,8'h12,16'h0000,8'h00,2'd3,4'd9,8'h1A,8'h09,1'b0}, // R7 crossing
        '{8'h5E,1'b0,8'h00,1'b0,1'b1,16'h0000,8'h80,8'h90,8'h00,8'h01,16'h0000,8'h00,2'd3,4'd8,8'h80,8'h00,1'b0}, // R7 R5
        '{8'h56,1'b1,8'hFF,1'b0,1'b0,16'h0000,8'h02,8'hA0,8'h80,8'h00,16'h0000,8'h00,2'd2,4'd7,8'h40,8'h00,1'b0}, // R6
        '{8'h56,1'b0,8'h00,1'b0,1'b0,16'h0000,8'h00,8'hB0,8'hFF,8'hFF,16'h0000,8'h01,2'd2,4'd8,8'hFF,8'h7F,1'b0}, // R5
        '{8'h4B,1'b1,8'h00,1'b0,1'b0,16'h5555,8'h3C,8'hC0,8'h11,8'h22,16'h5555,8'h3C,2'd0,4'd0,8'h11,8'h22,1'b1}, // R8
        '{8'h0A,1'b0,8'h00,1'b0,1'b0,16'hA5A5,8'hC3,8'hD0,8'h33,8'h44,16'hA5A5,8'hC3,2'd0,4'd0,8'h33,8'h44,1'b1}  // R8
    };

    task automatic wait_done(output bit ok);
        int t = 0;
        ok = 1'b1;
        do begin
            @(negedge clk);
            t++;
        end while (!done && t < 200);
        if (!done) begin
            ok = 1'b0;
            chk("R9", "done never seen", 32'd0, 32'd1);
        end
    endtask

    task automatic launch(input vec_t v);
        opcode        = v.op;
        acc_byte_mode = v.bm;
        dp_reg_lo     = v.dp;
        page_cross    = v.pc;
        compat_mode   = v.cm;
        acc_in        = v.acc;
        flags_in      = v.flg;
        eff_addr      = ADDR_W'(v.addr);
        start         = 1'b1;
        @(negedge clk);
        start         = 1'b0;
    endtask

    task automatic check_accesses(input vec_t v, input int base, input bit is_mem);
        int exp_n;
        exp_n = !is_mem ? 0 : (v.bm ? 2 : 4);
        chk("R5/R8", "access count", 32'(log_n - base), 32'(exp_n));
        if (is_mem && (log_n - base) == exp_n) begin
            for (int k = 0; k < exp_n; k++) begin
                logic [7:0] ea;
                logic       ew;
                if (v.bm) begin
                    ea = v.addr;
                    ew = (k == 1);
                end else begin
                    ea = v.addr + 8'(k % 2);
                    ew = (k >= 2);
                end
                chk("R5", "access address", 32'(log_addr[(base + k) % 64]), 32'(ea));
                chk("R5", "access direction", 32'(log_we[(base + k) % 64]), 32'(ew));
            end
        end
    endtask

    initial begin
        int wd = 0;
        while (wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        chk("R9", "watchdog expired", 32'd1, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        bit ok;
        int base;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // reset state, R11
        chk("R11", "busy", 32'(busy), 32'd0);
        chk("R11", "done", 32'(done), 32'd0);
        chk("R11", "mem_req", 32'(mem_req), 32'd0);
        chk("R11", "bad_opcode", 32'(bad_opcode), 32'd0);
        chk("R11", "acc_out", 32'(acc_out), 32'd0);
        chk("R11", "flags_out", 32'(flags_out), 32'd0);
        chk("R11", "len/cycles", {26'd0, instr_len, cycle_count}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            bit is_mem;
            v = VECS[i];
            is_mem = (v.op == OPC_ABS) || (v.op == OPC_DP) ||
                     (v.op == OPC_ABS_X) || (v.op == OPC_DP_X);
            mem[v.addr]        = v.mlo;
            mem[v.addr + 8'd1] = v.mhi;
            lat  = i % 3;
            base = log_n;
            launch(v);
            if (!done) wait_done(ok); else ok = 1'b1;
            if (ok) begin
                chk("R1/R3", "acc_out", 32'(acc_out), 32'(v.x_acc));
                chk("R1/R2", "flags_out", 32'(flags_out), 32'(v.x_flg));
                chk("R4", "instr_len", 32'(instr_len), 32'(v.x_len));
                chk("R4/R5/R6/R7", "cycle_count", 32'(cycle_count), 32'(v.x_cyc));
                chk("R8", "bad_opcode", 32'(bad_opcode), 32'(v.x_bad));
                @(negedge clk);
                chk("R9", "done width", 32'(done), 32'd0);
                chk("R5", "memory low byte", 32'(mem[v.addr]), 32'(v.x_mlo));
                chk("R5", "memory high byte", 32'(mem[v.addr + 8'd1]), 32'(v.x_mhi));
                check_accesses(v, base, is_mem);
            end
        end

        // R10: start pulse during a slow 16-bit memory operation is ignored
        begin
            vec_t v;
            int dones;
            v = '{8'h4E,1'b0,8'h00,1'b0,1'b0,16'h1111,8'h00,8'hE0,8'h02,8'h00,
                  16'h1111,8'h00,2'd3,4'd8,8'h01,8'h00,1'b0};
            mem[8'hE0] = 8'h02;
            mem[8'hE1] = 8'h00;
            lat  = 3;
            base = log_n;
            launch(v);
            @(negedge clk);
            chk("R10", "busy during run", 32'(busy), 32'd1);
            opcode = OPC_ACC;
            acc_in = 16'hFFFF;
            flags_in = 8'hFF;
            start  = 1'b1;
            @(negedge clk);
            start  = 1'b0;
            wait_done(ok);
            if (ok) begin
                chk("R10", "acc_out", 32'(acc_out), 32'h1111);
                chk("R10", "flags_out", 32'(flags_out), 32'h00);
                chk("R10", "cycle_count", 32'(cycle_count), 32'd8);
                chk("R10", "memory low byte", 32'(mem[8'hE0]), 32'h01);
                check_accesses(v, base, 1'b1);
                dones = 0;
                for (int k = 0; k < 6; k++) begin
                    @(negedge clk);
                    if (done) dones++;
                end
                chk("R10", "extra done pulses", 32'(dones), 32'd0);
                chk("R10", "busy after run", 32'(busy), 32'd0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule